// File: doc/BRIEF.md
# Shared-Counter Multi-Channel PWM Timer

This block is a register-mapped pulse-width modulator in which several output channels share a single up-counter and one period (modulo) value. A power-of-two prescaler sets the counting rate. Each channel has its own compare value, which sets its duty, and its own control byte, which enables the output and selects its polarity. Software programs everything through a simple 32-bit write/read register port: a write strobe, a byte address and write data, with read data returned combinationally from the address.

Since the counter and period are common, the period and the prescaler may change only under controlled conditions. The prescaler field is accepted only while the counter is stopped. While the counter runs, new modulo and compare values are held in a buffer and take effect together at the counter wrap. While it is stopped they take effect at once. Each channel also has a match flag that records when the counter reaches its compare value. Software clears the flag by writing a one to it.

Top module: `pwm_timer`

## Requirements
- R1: After reset the counter reads 0, the modulo reads 0xFFFF, the control register reads 0, every channel control and value reads 0, and every PWM output is low.
- R2: Address 0x04 returns the channel count in bits [7:0]. Address 0x08, every unassigned address and every channel slot at or above the channel count read 0.
- R3: The control register at 0x10 holds the clock mode in bits [4:3] and the prescaler PS in bits [2:0]. With mode 01 the counter advances once every 2^PS clocks; every other mode holds it. A write to PS is accepted only if the mode was 00 before that write, but the mode field itself is always written. Bit 5 reads 0 and has no effect.
- R4: The counter at 0x14 advances from 0 up to the active modulo. On the step after it reaches the modulo (or if it is already above it) it returns to 0. Any write to 0x14 clears the counter and the prescaler phase.
- R5: The modulo at 0x18 is 16 bits wide and reads back the last value written. While the mode is not 01 the new value becomes active the next cycle. While running, it becomes active at the wrap step, including a value written in the wrap cycle itself.
- R6: Channel n's compare value at 0x24+8n follows the same read-back and buffering rule as the modulo.
- R7: Channel n's control at 0x20+8n holds mode-select B in bit 5, mode-select A in bit 4 and the level field in bits [3:2]. The output is driven only when B=1, A=0 and the level field is 10 or 01; in every other case the output is low.
- R8: With level 10 the output is high while the counter is below the active compare value. With level 01 it is the complement.
- R9: A compare value of 0 gives a constant inactive level, and a compare value above the modulo gives a constant active level.
- R10: Bit 7 of channel n's control is a flag. It is set by a counting step on which the counter equals the active compare value. Writing 1 to it clears it and writing 0 leaves it unchanged. If a set and a clear fall in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W (8) | Byte address of the register |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data for bus_addr |
| pwm_out | output | NUM_CH (4) | One PWM output per channel |

## Verification
Two pairs of events can land in the same cycle. The first is a match flag being set by a counting step while software writes a one to clear it. The second is a modulo or compare write that lands exactly on the wrap step. A directed sequence starts the counter from a cleared state and counts the cycles so that the clear write meets the match step; the flag must then read set, and a second clear one cycle later must leave it clear. Long random runs with small periods, frequent flag-clear writes and buffered value writes hit both coincidences many times. Every output and every read is judged against a bench model that applies set-over-clear and load-at-wrap.

// File: rtl/pwm_timer_pkg.sv
`timescale 1ns/1ps
package pwm_timer_pkg;

    localparam int unsigned OFS_PARAM = 32'h04;
    localparam int unsigned OFS_CTRL  = 32'h10;
    localparam int unsigned OFS_COUNT = 32'h14;
    localparam int unsigned OFS_MOD   = 32'h18;
    localparam int unsigned OFS_CH    = 32'h20;
    localparam int unsigned CH_STRIDE = 8;

    typedef enum logic [1:0] {
        CLK_STOP = 2'b00,
        CLK_RUN  = 2'b01,
        CLK_RSV2 = 2'b10,
        CLK_RSV3 = 2'b11
    } clk_mode_e;

    typedef enum logic [1:0] {
        LVL_OFF  = 2'b00,
        LVL_INV  = 2'b01,
        LVL_NORM = 2'b10,
        LVL_RSV  = 2'b11
    } lvl_e;

    // bit order matches control bits [5:2]
    typedef struct packed {
        logic sel_b;
        logic sel_a;
        lvl_e level;
    } ch_cfg_t;

    function automatic logic cfg_drives(ch_cfg_t c);
        return c.sel_b && !c.sel_a && (c.level == LVL_NORM || c.level == LVL_INV);
    endfunction

endpackage

// File: rtl/pwm_prescale.sv
`timescale 1ns/1ps
module pwm_prescale #(
    parameter int PS_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run_i,
    input  logic            clr_i,
    input  logic [PS_W-1:0] ps_i,
    output logic            tick_o
);
    localparam int PH_W = (1 << PS_W) - 1;

    typedef struct packed {
        logic [PH_W-1:0] phase;
    } st_t;

    st_t st_d, st_q;
    logic [PH_W:0]   span;
    logic [PH_W-1:0] limit;

    always_comb begin
        span   = {{PH_W{1'b0}}, 1'b1} << ps_i;
        limit  = span[PH_W-1:0] - {{(PH_W-1){1'b0}}, 1'b1};
        tick_o = run_i && (st_q.phase == limit);
        st_d   = st_q;
        if (!run_i || clr_i)         st_d.phase = '0;
        else if (st_q.phase >= limit) st_d.phase = '0;
        else                          st_d.phase = st_q.phase + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R3
    tick_every_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && ps_i == '0) |-> tick_o);

endmodule

// File: rtl/pwm_counter.sv
`timescale 1ns/1ps
module pwm_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             run_i,
    input  logic             clr_i,
    input  logic             mod_wr_i,
    input  logic [CNT_W-1:0] mod_wdata_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] mod_buf_o,
    output logic [CNT_W-1:0] mod_act_o,
    output logic             wrap_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] mod_buf;
        logic [CNT_W-1:0] mod_act;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        wrap_o = tick_i && (st_q.cnt >= st_q.mod_act);
        st_d   = st_q;
        if (clr_i)       st_d.cnt = '0;
        else if (wrap_o) st_d.cnt = '0;
        else if (tick_i) st_d.cnt = st_q.cnt + 1'b1;
        if (mod_wr_i) st_d.mod_buf = mod_wdata_i;
        if (!run_i || wrap_o) st_d.mod_act = st_d.mod_buf;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cnt     <= '0;
            st_q.mod_buf <= '1;
            st_q.mod_act <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o     = st_q.cnt;
    assign mod_buf_o = st_q.mod_buf;
    assign mod_act_o = st_q.mod_act;

    // R4
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !clr_i) |=> $stable(cnt_o));
    // R4
    wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_o |=> (cnt_o == '0));
    // R5
    mod_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !wrap_o) |=> $stable(mod_act_o));

endmodule

// File: rtl/pwm_channel.sv
`timescale 1ns/1ps
module pwm_channel
    import pwm_timer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             tick_i,
    input  logic             wrap_i,
    input  logic             run_i,
    input  logic             cfg_wr_i,
    input  logic [7:0]       cfg_wdata_i,
    input  logic             val_wr_i,
    input  logic [CNT_W-1:0] val_wdata_i,
    output logic             pwm_o,
    output logic             flag_o,
    output ch_cfg_t          cfg_o,
    output logic [CNT_W-1:0] val_buf_o
);
    typedef struct packed {
        ch_cfg_t          cfg;
        logic             flag;
        logic [CNT_W-1:0] val_buf;
        logic [CNT_W-1:0] val_act;
    } st_t;

    st_t  st_d, st_q;
    logic hit;
    logic active;
    logic unused_cfg_bits;

    assign unused_cfg_bits = ^{cfg_wdata_i[6], cfg_wdata_i[1:0]};

    always_comb begin
        hit  = tick_i && (cnt_i == st_q.val_act);
        st_d = st_q;
        if (cfg_wr_i) st_d.cfg = ch_cfg_t'(cfg_wdata_i[5:2]);
        if (hit)                            st_d.flag = 1'b1;
        else if (cfg_wr_i && cfg_wdata_i[7]) st_d.flag = 1'b0;
        if (val_wr_i) st_d.val_buf = val_wdata_i;
        if (!run_i || wrap_i) st_d.val_act = st_d.val_buf;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        active = cnt_i < st_q.val_act;
        pwm_o  = cfg_drives(st_q.cfg) && ((st_q.cfg.level == LVL_NORM) ? active : !active);
    end

    assign flag_o    = st_q.flag;
    assign cfg_o     = st_q.cfg;
    assign val_buf_o = st_q.val_buf;

    // R10
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && cnt_i == st_q.val_act) |=> flag_o);
    // R10
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_i && cfg_wdata_i[7] && !(tick_i && cnt_i == st_q.val_act)) |=> !flag_o);
    // R6
    val_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !wrap_i) |=> $stable(st_q.val_act));

endmodule

// File: rtl/pwm_timer.sv
`timescale 1ns/1ps
module pwm_timer
    import pwm_timer_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int CNT_W  = 16,
    parameter int PS_W   = 3,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NUM_CH-1:0] pwm_out
);
    localparam int CM_LSB = PS_W;
    localparam logic [ADDR_W-1:0] A_PARAM = ADDR_W'(OFS_PARAM);
    localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_COUNT = ADDR_W'(OFS_COUNT);
    localparam logic [ADDR_W-1:0] A_MOD   = ADDR_W'(OFS_MOD);

    typedef struct packed {
        clk_mode_e        mode;
        logic [PS_W-1:0]  ps;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;
    logic  run;
    logic  tick;
    logic  wrap;
    logic  cnt_clr;
    logic  unused_wdata;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] mod_buf;
    logic [CNT_W-1:0] mod_act;
    logic             flag_w [NUM_CH];
    ch_cfg_t          cfg_w  [NUM_CH];
    logic [CNT_W-1:0] vbuf_w [NUM_CH];

    assign unused_wdata = ^bus_wdata;
    assign run          = (ctrl_q.mode == CLK_RUN);
    assign cnt_clr      = bus_wr && (bus_addr == A_COUNT);

    always_comb begin
        ctrl_d = ctrl_q;
        if (bus_wr && bus_addr == A_CTRL) begin
            ctrl_d.mode = clk_mode_e'(bus_wdata[CM_LSB+1:CM_LSB]);
            if (ctrl_q.mode == CLK_STOP) ctrl_d.ps = bus_wdata[PS_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    pwm_prescale #(.PS_W(PS_W)) u_prescale (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (run),
        .clr_i  (cnt_clr),
        .ps_i   (ctrl_q.ps),
        .tick_o (tick)
    );

    pwm_counter #(.CNT_W(CNT_W)) u_counter (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick),
        .run_i       (run),
        .clr_i       (cnt_clr),
        .mod_wr_i    (bus_wr && bus_addr == A_MOD),
        .mod_wdata_i (bus_wdata[CNT_W-1:0]),
        .cnt_o       (cnt),
        .mod_buf_o   (mod_buf),
        .mod_act_o   (mod_act),
        .wrap_o      (wrap)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        localparam logic [ADDR_W-1:0] A_CFG = ADDR_W'(OFS_CH + CH_STRIDE * g);
        localparam logic [ADDR_W-1:0] A_VAL = ADDR_W'(OFS_CH + CH_STRIDE * g + 4);

        pwm_channel #(.CNT_W(CNT_W)) u_ch (
            .clk         (clk),
            .rst_n       (rst_n),
            .cnt_i       (cnt),
            .tick_i      (tick),
            .wrap_i      (wrap),
            .run_i       (run),
            .cfg_wr_i    (bus_wr && bus_addr == A_CFG),
            .cfg_wdata_i (bus_wdata[7:0]),
            .val_wr_i    (bus_wr && bus_addr == A_VAL),
            .val_wdata_i (bus_wdata[CNT_W-1:0]),
            .pwm_o       (pwm_out[g]),
            .flag_o      (flag_w[g]),
            .cfg_o       (cfg_w[g]),
            .val_buf_o   (vbuf_w[g])
        );
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == A_PARAM)      bus_rdata[7:0] = 8'(NUM_CH);
        else if (bus_addr == A_CTRL)  bus_rdata[PS_W+1:0] = {ctrl_q.mode, ctrl_q.ps};
        else if (bus_addr == A_COUNT) bus_rdata[CNT_W-1:0] = cnt;
        else if (bus_addr == A_MOD)   bus_rdata[CNT_W-1:0] = mod_buf;
        for (int i = 0; i < NUM_CH; i++) begin
            if (bus_addr == ADDR_W'(OFS_CH + CH_STRIDE * i))
                bus_rdata[7:0] = {flag_w[i], 1'b0, cfg_w[i], 2'b00};
            if (bus_addr == ADDR_W'(OFS_CH + CH_STRIDE * i + 4))
                bus_rdata[CNT_W-1:0] = vbuf_w[i];
        end
    end

    // R3
    ps_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.mode != CLK_STOP) |=> $stable(ctrl_q.ps));
    // R4
    cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_clr |=> (cnt == '0));

endmodule

// File: tb/pwm_timer_bench.sv
`timescale 1ns/1ps
module pwm_timer_bench;
    localparam int NCH = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [NCH-1:0] pwm_out;

    int n_checks = 0;
    int n_err = 0;

    always #10 clk = ~clk;

    pwm_timer u_pwm_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pwm_out   (pwm_out)
    );

    // ---------------- reference model ----------------
    logic [1:0]  m_mode;
    logic [2:0]  m_ps;
    logic [6:0]  m_pre;
    logic [15:0] m_cnt, m_mbuf, m_mact;
    logic [3:0]  m_cfg  [NCH];
    logic        m_flag [NCH];
    logic [15:0] m_vbuf [NCH];
    logic [15:0] m_vact [NCH];

    task automatic m_reset();
        m_mode = 0; m_ps = 0; m_pre = 0; m_cnt = 0; m_mbuf = 16'hFFFF; m_mact = 16'hFFFF;
        for (int i = 0; i < NCH; i++) begin
            m_cfg[i] = 0; m_flag[i] = 0; m_vbuf[i] = 0; m_vact[i] = 0;
        end
    endtask

    task automatic m_step();
        logic run, tk, clr, wrp, hit;
        logic [6:0]  lim;
        logic [15:0] old_cnt;
        run = (m_mode == 2'b01);
        lim = 7'((8'd1 << m_ps) - 8'd1);
        tk  = run && (m_pre == lim);
        clr = bus_wr && bus_addr == 8'h14;
        wrp = tk && (m_cnt >= m_mact);
        old_cnt = m_cnt;
        if (!run || clr) m_pre = 0;
        else if (m_pre >= lim) m_pre = 0;
        else m_pre = m_pre + 1;
        if (clr || wrp) m_cnt = 0;
        else if (tk) m_cnt = m_cnt + 1;
        if (bus_wr && bus_addr == 8'h18) m_mbuf = bus_wdata[15:0];
        if (!run || wrp) m_mact = m_mbuf;
        for (int i = 0; i < NCH; i++) begin
            hit = tk && (old_cnt == m_vact[i]);
            if (bus_wr && bus_addr == 8'(32 + 8 * i)) begin
                m_cfg[i] = bus_wdata[5:2];
                if (bus_wdata[7]) m_flag[i] = 0;
            end
            if (hit) m_flag[i] = 1;
            if (bus_wr && bus_addr == 8'(36 + 8 * i)) m_vbuf[i] = bus_wdata[15:0];
            if (!run || wrp) m_vact[i] = m_vbuf[i];
        end
        if (bus_wr && bus_addr == 8'h10) begin
            if (m_mode == 2'b00) m_ps = bus_wdata[2:0];
            m_mode = bus_wdata[4:3];
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) m_reset();
        else        m_step();
    end

    function automatic logic m_pwm(int i);
        logic en, act;
        en  = m_cfg[i][3] && !m_cfg[i][2] && (m_cfg[i][1:0] == 2'b10 || m_cfg[i][1:0] == 2'b01);
        act = m_cnt < m_vact[i];
        return en && ((m_cfg[i][1:0] == 2'b10) ? act : !act);
    endfunction

    function automatic logic [31:0] m_read(logic [7:0] a);
        if (a == 8'h04) return 32'(NCH);
        if (a == 8'h10) return {27'd0, m_mode, m_ps};
        if (a == 8'h14) return {16'd0, m_cnt};
        if (a == 8'h18) return {16'd0, m_mbuf};
        for (int i = 0; i < NCH; i++) begin
            if (a == 8'(32 + 8 * i)) return {24'd0, m_flag[i], 1'b0, m_cfg[i], 2'b00};
            if (a == 8'(36 + 8 * i)) return {16'd0, m_vbuf[i]};
        end
        return 32'd0;
    endfunction

    function automatic string tag_of(logic [7:0] a);
        if (a == 8'h10) return "R3";
        if (a == 8'h14) return "R4";
        if (a == 8'h18) return "R5";
        if (a >= 8'h20 && a < 8'(32 + 8 * NCH)) return a[2] ? "R6" : "R10";
        return "R2";
    endfunction

    // ---------------- checking helpers ----------------
    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_pwm();
        for (int i = 0; i < NCH; i++) begin
            string t;
            if (!(m_cfg[i][3] && !m_cfg[i][2] && (m_cfg[i][1:0] == 2'b10 || m_cfg[i][1:0] == 2'b01)))
                t = "R7";
            else if (m_vact[i] == 0 || m_vact[i] > m_mact) t = "R9";
            else t = "R8";
            chk(t, 32'(pwm_out[i]), 32'(m_pwm(i)));
        end
    endtask

    task automatic cycle();
        @(posedge clk);
        #5;
        check_pwm();
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        cycle();
        bus_wr = 1'b0;
    endtask

    task automatic rd_model(logic [7:0] a);
        bus_addr = a;
        #1;
        chk(tag_of(a), bus_rdata, m_read(a));
    endtask

    task automatic rd_exp(string tag, logic [7:0] a, logic [31:0] exp);
        bus_addr = a;
        #1;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
        $finish;
    end

    initial begin
        int unsigned seed_sink;
        seed_sink = $urandom(32'd4242);
        repeat (3) @(posedge clk);
        #5 rst_n = 1'b1;
        cycle();

        // R1 reset state
        rd_exp("R1", 8'h14, 32'h0);
        rd_exp("R1", 8'h18, 32'hFFFF);
        rd_exp("R1", 8'h10, 32'h0);
        for (int i = 0; i < NCH; i++) begin
            rd_exp("R1", 8'(32 + 8 * i), 32'h0);
            rd_exp("R1", 8'(36 + 8 * i), 32'h0);
        end
        chk("R1", 32'(pwm_out), 32'h0);
        // R2 parameter and unmapped reads
        rd_exp("R2", 8'h04, 32'(NCH));
        rd_exp("R2", 8'h08, 32'h0);
        rd_exp("R2", 8'h40, 32'h0);
        rd_exp("R2", 8'h00, 32'h0);

        // channels: normal v4, inverted v7, normal v0, normal v12 (>mod), mod=9
        wr(8'h18, 32'd9);
        wr(8'h24, 32'd4);  wr(8'h20, 32'h28);
        wr(8'h2C, 32'd7);  wr(8'h28, 32'h24);
        wr(8'h34, 32'd0);  wr(8'h30, 32'h28);
        wr(8'h3C, 32'd12); wr(8'h38, 32'h28);
        wr(8'h10, 32'h08);
        for (int k = 0; k < 40; k++) cycle();
        rd_model(8'h14);

        // R3 prescaler locked while running
        wr(8'h10, 32'h0A);
        rd_exp("R3", 8'h10, 32'h08);
        wr(8'h10, 32'h02);
        rd_exp("R3", 8'h10, 32'h00);
        wr(8'h10, 32'h2A);
        rd_exp("R3", 8'h10, 32'h0A);
        for (int k = 0; k < 60; k++) cycle();
        rd_model(8'h14);

        // R10 set and clear in the same cycle: set wins
        wr(8'h10, 32'h00);
        wr(8'h14, 32'h0);
        wr(8'h18, 32'd9);
        wr(8'h24, 32'd3);
        wr(8'h20, 32'hA8);
        rd_exp("R10", 8'h20, 32'h28);
        wr(8'h10, 32'h08);
        cycle(); cycle(); cycle();
        wr(8'h20, 32'hA8);
        rd_exp("R10", 8'h20, 32'hA8);
        rd_exp("R4", 8'h14, 32'd4);
        wr(8'h20, 32'hA8);
        rd_exp("R10", 8'h20, 32'h28);
        wr(8'h20, 32'h28);
        rd_exp("R10", 8'h20, 32'h28);

        // R5 buffered modulo while running
        wr(8'h18, 32'd5);
        rd_exp("R5", 8'h18, 32'd5);
        for (int k = 0; k < 30; k++) cycle();
        rd_model(8'h14);

        // random phase
        for (int k = 0; k < 6000; k++) begin
            int unsigned r;
            r = $urandom % 100;
            if (r < 30) begin
                int unsigned sel;
                int unsigned ch;
                sel = $urandom % 10;
                ch  = $urandom % NCH;
                if (sel == 0) begin
                    logic [1:0] md;
                    md = ($urandom % 6 == 0) ? 2'($urandom) : 2'b01;
                    wr(8'h10, {26'd0, 1'($urandom), md, 3'($urandom % 3)});
                end else if (sel == 1) begin
                    if ($urandom % 4 == 0) wr(8'h14, $urandom);
                    else wr(8'h18, 32'($urandom % 21));
                end else if (sel < 6) begin
                    logic [1:0] lv;
                    lv = 2'($urandom);
                    wr(8'(32 + 8 * ch), {24'd0, 1'($urandom), 1'b0,
                        ($urandom % 5 != 0), ($urandom % 5 == 0), lv, 2'($urandom)});
                end else begin
                    wr(8'(36 + 8 * ch), {16'($urandom), 16'($urandom % 23)});
                end
            end else begin
                cycle();
            end
            if ($urandom % 5 == 0) begin
                logic [7:0] a;
                case ($urandom % 8)
                    0: a = 8'h04;
                    1: a = 8'h10;
                    2: a = 8'h14;
                    3: a = 8'h18;
                    4: a = 8'h08;
                    5: a = 8'h40;
                    default: a = 8'(32 + 8 * ($urandom % NCH) + 4 * ($urandom % 2));
                endcase
                rd_model(a);
            end
        end

        summary();
        $finish;
    end

endmodule